// File: doc/BRIEF.md
# Serial Debug RAM Rewrite Engine

This block is a debug slave that lets an external host overwrite one 32-bit word of on-chip RAM through a clocked serial link. The block runs on the serial clock: one received bit, one transmitted bit and one possible RAM access per cycle. The link is divided into back-to-back frames of 32 cycles. A frame counter starts at zero in the first cycle after reset and wraps every 32 cycles.

The host sends a command frame that holds a rewrite code and a byte address, then a frame that holds the write data. The engine then reads the target word, writes the new word and reads it back. It uses only cycles in which the CPU is not using the RAM port, so the processor never stalls.

The value read before the write and the value read after it go back to the host on the transmit line in two consecutive frames. A short acknowledge pulse at the start of the next frame closes the sequence.

Top module: `dbg_ram_rewrite`

## Requirements
- R1: Frames are 32 cycles long. The first frame begins in the first cycle after reset is released. Bit k of a frame is received (and transmitted) in the frame's k-th cycle, so words travel least-significant bit first.
- R2: While waiting, a frame whose bits 19:16 equal 4'b0011 is a rewrite command. Frame bits ADDR_W-1:0 are a byte address. The word address driven on `ram_addr` is byte-address bits ADDR_W-1:2, so the two lowest bits are ignored. Bits 31:20 of the frame are ignored.
- R3: A frame with any other value in bits 19:16 causes no RAM access, no transmit data and no acknowledge. The engine keeps waiting for a command frame.
- R4: The frame that directly follows an accepted command frame is taken as the 32-bit write data.
- R5: From the cycle after the data frame's last bit, the engine issues a read, then a write, then a read, all at the same word address. Each access is issued in the first cycle at or after its turn in which `cpu_busy` is low. `ram_en` is never high while `cpu_busy` is high.
- R6: The RAM returns read data one cycle after the read is issued. The engine captures both read results in that cycle.
- R7: Transmit starts at the first frame that begins after the cycle in which the post-write read data is captured. That frame carries the pre-write word and the following frame carries the post-write word. `tx_bit` is low in all other cycles.
- R8: `ack` is high for exactly the first three cycles of the frame that follows the post-write transmit frame.
- R9: Frames that arrive from the start of the access frame through the end of the post-write transmit frame are not decoded. A command frame may arrive during the acknowledge frame and is accepted.
- R10: While reset is high, `ack`, `tx_bit` and `ram_en` are low, the frame counter returns to zero and the engine returns to waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, which also clocks the RAM port |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data from the host |
| tx_bit | output | 1 | Serial transmit data to the host |
| ack | output | 1 | Completion pulse to the host |
| cpu_busy | input | 1 | High when the CPU uses the RAM port in this cycle |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | Write select, valid with ram_en |
| ram_addr | output | ADDR_W-2 | Word address |
| ram_wdata | output | 32 | Write data |
| ram_rdata | input | 32 | Read data, valid one cycle after a read |

## Verification
Two things can fall in the same cycle: the capture of the verify read and the last bit of a frame. Holding `cpu_busy` high for the first 28 cycles of an access frame pushes the three accesses into bit positions 28 to 30. The capture then lands on position 31, and the pre-write word must start in the very next frame rather than one frame later. A second collision is a new command frame that arrives inside the acknowledge frame. That command must be decoded while `ack` is still shaped correctly. A per-cycle behavioural model in the bench judges both cases on `tx_bit`, `ack` and every RAM strobe.

// File: rtl/dbg_rw_pkg.sv
package dbg_rw_pkg;

    localparam int FRAME_BITS = 32;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int CODE_LSB   = 16;
    localparam int CODE_W     = 4;
    localparam logic [CODE_W-1:0] CODE_REWRITE = 4'b0011;

    typedef logic [FRAME_BITS-1:0] word_t;
    typedef logic [CNT_W-1:0]      bitpos_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_ACCESS,
        ST_HOLD,
        ST_TX_OLD,
        ST_TX_NEW,
        ST_ACK
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_RD_OLD,
        PH_WRITE,
        PH_RD_NEW,
        PH_CAPTURE
    } acc_phase_e;

    typedef struct packed {
        word_t old_word;
        word_t new_word;
    } verify_pair_t;

    function automatic logic is_rewrite(word_t f);
        return f[CODE_LSB +: CODE_W] == CODE_REWRITE;
    endfunction

    function automatic logic at_frame_end(bitpos_t p);
        return p == bitpos_t'(FRAME_BITS - 1);
    endfunction

endpackage

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
    import dbg_rw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rx_bit,
    output bitpos_t bit_idx,
    output logic    frame_last,
    output word_t   frame_word
);

    word_t   shreg;
    bitpos_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else begin
            cnt   <= at_frame_end(cnt) ? '0 : cnt + 1'b1;
            shreg <= {rx_bit, shreg[FRAME_BITS-1:1]};
        end
    end

    assign bit_idx    = cnt;
    assign frame_last = at_frame_end(cnt);
    assign frame_word = {rx_bit, shreg[FRAME_BITS-1:1]};

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> (bit_idx == '0)); // R1

endmodule

// File: rtl/dbg_ram_seq.sv
module dbg_ram_seq
    import dbg_rw_pkg::*;
#(
    parameter int WA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [WA_W-1:0] word_addr,
    input  word_t           wr_word,
    input  logic            cpu_busy,
    output logic            ram_en,
    output logic            ram_we,
    output logic [WA_W-1:0] ram_addr,
    output word_t           ram_wdata,
    input  word_t           ram_rdata,
    output verify_pair_t    pair,
    output logic            done
);

    acc_phase_e   phase;
    logic         active;
    logic         old_pending;
    verify_pair_t pair_q;
    logic         issue;

    assign issue     = active && (phase != PH_CAPTURE) && !cpu_busy;
    assign ram_en    = issue;
    assign ram_we    = issue && (phase == PH_WRITE);
    assign ram_addr  = word_addr;
    assign ram_wdata = wr_word;
    assign done      = active && (phase == PH_CAPTURE);
    assign pair      = pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            phase       <= PH_RD_OLD;
            old_pending <= 1'b0;
            pair_q      <= '0;
        end else begin
            old_pending <= issue && (phase == PH_RD_OLD);
            if (old_pending) begin
                pair_q.old_word <= ram_rdata;
            end
            if (start) begin
                active <= 1'b1;
                phase  <= PH_RD_OLD;
            end else if (done) begin
                pair_q.new_word <= ram_rdata;
                active          <= 1'b0;
                phase           <= PH_RD_OLD;
            end else if (issue) begin
                unique case (phase)
                    PH_RD_OLD: phase <= PH_WRITE;
                    PH_WRITE:  phase <= PH_RD_NEW;
                    default:   phase <= PH_CAPTURE;
                endcase
            end
        end
    end

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cpu_busy |-> !ram_en); // R5

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        (ram_en && ram_we) |-> (phase == PH_WRITE && active)); // R5

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

endmodule

// File: rtl/dbg_frame_tx.sv
module dbg_frame_tx
    import dbg_rw_pkg::*;
(
    input  logic         sel_old,
    input  logic         sel_new,
    input  bitpos_t      bit_idx,
    input  verify_pair_t pair,
    output logic         tx_bit
);

    always_comb begin
        tx_bit = 1'b0;
        if (sel_old) begin
            tx_bit = pair.old_word[bit_idx];
        end else if (sel_new) begin
            tx_bit = pair.new_word[bit_idx];
        end
    end

endmodule

// File: rtl/dbg_ram_rewrite.sv
module dbg_ram_rewrite
    import dbg_rw_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int ACK_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic              ack,
    input  logic              cpu_busy,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-3:0] ram_addr,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata
);

    localparam int WA_W = ADDR_W - 2;

    ctl_state_e      state;
    bitpos_t         bit_idx;
    logic            frame_last;
    word_t           frame_word;
    logic [WA_W-1:0] cmd_addr;
    word_t           data_q;
    logic            seq_start;
    logic            seq_done;
    verify_pair_t    pair;

    dbg_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_bit     (rx_bit),
        .bit_idx    (bit_idx),
        .frame_last (frame_last),
        .frame_word (frame_word)
    );

    assign seq_start = (state == ST_DATA) && frame_last;

    dbg_ram_seq #(.WA_W(WA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .word_addr (cmd_addr),
        .wr_word   (data_q),
        .cpu_busy  (cpu_busy),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .pair      (pair),
        .done      (seq_done)
    );

    dbg_frame_tx u_tx (
        .sel_old (state == ST_TX_OLD),
        .sel_new (state == ST_TX_NEW),
        .bit_idx (bit_idx),
        .pair    (pair),
        .tx_bit  (tx_bit)
    );

    assign ack = (state == ST_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cmd_addr <= '0;
            data_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frame_last && is_rewrite(frame_word)) begin
                        cmd_addr <= frame_word[ADDR_W-1:2];
                        state    <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (frame_last) begin
                        data_q <= frame_word;
                        state  <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (seq_done) begin
                        state <= frame_last ? ST_TX_OLD : ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (frame_last) state <= ST_TX_OLD;
                end
                ST_TX_OLD: begin
                    if (frame_last) state <= ST_TX_NEW;
                end
                ST_TX_NEW: begin
                    if (frame_last) state <= ST_ACK;
                end
                ST_ACK: begin
                    if (bit_idx == bitpos_t'(ACK_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DATA_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> ($past(state) == ST_IDLE || $past(state) == ST_DATA)); // R2

    AST_ACK_AT_FRAME_START: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> (bit_idx == '0)); // R8

    AST_TX_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_ACCESS) |-> !tx_bit); // R7

    AST_NO_RAM_OUTSIDE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> (state == ST_ACCESS)); // R9

endmodule

// File: tb/dbg_ram_rewrite_tb.sv
`timescale 1ns/1ps
module dbg_ram_rewrite_tb;

    localparam int ADDR_W = 10;
    localparam int WA_W   = ADDR_W - 2;
    localparam int NWORDS = 1 << WA_W;
    localparam int NFRAMES = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic cpu_busy = 1'b0;
    logic tx_bit, ack, ram_en, ram_we;
    logic [WA_W-1:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata;

    always #2 clk = ~clk;

    dbg_ram_rewrite #(.ADDR_W(ADDR_W), .ACK_CYC(3)) u_dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .tx_bit(tx_bit), .ack(ack),
        .cpu_busy(cpu_busy), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    logic [31:0] ram_mem [NWORDS];
    logic [31:0] ref_mem [NWORDS];

    always_ff @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram_mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= ram_mem[ram_addr];
        end
    end

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    logic [31:0] frames [NFRAMES];

    function automatic logic busy_at(int t, logic [15:0] lf);
        if (t < 64) return lf[0];
        if (t >= 256 && t < 288) return lf[0];
        if (t >= 448 && t < 490) return 1'b1;
        if (t >= 640 && t < 668) return 1'b1;
        return 1'b0;
    endfunction

    // behavioural reference: 0 wait,1 data,2 access,3 hold,4 tx old,5 tx new,6 ack
    int md, step;
    logic [WA_W-1:0] m_addr;
    logic [31:0] m_wd, m_old, m_new, rxacc;
    int n_access, n_ack;

    initial begin : watchdog
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [15:0] lf;
        for (int i = 0; i < NWORDS; i++) begin
            ram_mem[i] = 32'h5A00_0000 ^ (i * 32'h0101_0103);
            ref_mem[i] = ram_mem[i];
        end
        for (int f = 0; f < NFRAMES; f++) frames[f] = 32'h0;
        frames[0]  = 32'h0003_0104;
        frames[1]  = 32'hA5A5_1234;
        frames[3]  = 32'hFFF3_0008;   // arrives during transmit, must be ignored
        frames[5]  = 32'h0005_0020;   // unknown code
        frames[6]  = 32'hFFF3_0207;   // high bits set, low address bits set
        frames[7]  = 32'h0F0F_C3C3;
        frames[12] = 32'h0003_0012;
        frames[13] = 32'hDEAD_BEEF;
        frames[18] = 32'h0003_0010;   // lands in the acknowledge frame
        frames[19] = 32'h1357_9BDF;

        md = 0; step = 0; m_addr = '0; m_wd = '0; m_old = '0; m_new = '0;
        rxacc = '0; n_access = 0; n_ack = 0;
        lf = 16'hACE1;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "ack in reset", 32'(ack), 32'd0);
        check("R10", "tx in reset", 32'(tx_bit), 32'd0);
        check("R10", "ram_en in reset", 32'(ram_en), 32'd0);
        rst = 1'b0;

        for (int t = 0; t < NFRAMES * 32; t++) begin
            int pos;
            logic b;
            logic exp_en, exp_tx, exp_ack;
            pos = t % 32;
            b = frames[t / 32][pos];
            rx_bit = b;
            cpu_busy = busy_at(t, lf);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            #1;
            exp_en  = (md == 2) && (step < 3) && !cpu_busy;
            exp_tx  = (md == 4) ? m_old[pos] : (md == 5) ? m_new[pos] : 1'b0;
            exp_ack = (md == 6);
            check("R5", "ram_en", 32'(ram_en), 32'(exp_en));
            if (exp_en) begin
                check("R5", "ram_we", 32'(ram_we), 32'(step == 1));
                check("R2", "ram_addr", 32'(ram_addr), 32'(m_addr));
                if (step == 1) check("R4", "ram_wdata", ram_wdata, m_wd);
                n_access++;
            end
            check("R7", "tx_bit (R6 capture)", 32'(tx_bit), 32'(exp_tx));
            check("R8", "ack", 32'(ack), 32'(exp_ack));
            if (ack && pos == 0) begin
                n_ack++;
                check("R1", "ack frame alignment", 32'(pos), 32'd0);
            end
            // advance reference across the coming edge
            rxacc[pos] = b;
            case (md)
                0: if (pos == 31 && rxacc[19:16] == 4'b0011) begin
                       m_addr = rxacc[ADDR_W-1:2];
                       md = 1;
                   end
                1: if (pos == 31) begin m_wd = rxacc; md = 2; step = 0; end
                2: begin
                       if (step == 3) begin
                           m_new = ref_mem[m_addr];
                           md = (pos == 31) ? 4 : 3;
                       end else if (!cpu_busy) begin
                           if (step == 0) m_old = ref_mem[m_addr];
                           if (step == 1) ref_mem[m_addr] = m_wd;
                           step++;
                       end
                   end
                3: if (pos == 31) md = 4;
                4: if (pos == 31) md = 5;
                5: if (pos == 31) md = 6;
                6: if (pos == 2) md = 0;
                default: md = 0;
            endcase
            @(negedge clk);
        end

        check("R4", "word 0x41 written", ram_mem[8'h41], 32'hA5A5_1234);
        check("R2", "word 0x81 written, low bits ignored", ram_mem[8'h81], 32'h0F0F_C3C3);
        check("R5", "word 4 rewritten twice", ram_mem[4], 32'h1357_9BDF);
        check("R9", "word 2 untouched", ram_mem[2], 32'h5A00_0000 ^ (2 * 32'h0101_0103));
        check("R3", "word 8 untouched", ram_mem[8], 32'h5A00_0000 ^ (8 * 32'h0101_0103));
        check("R3", "total RAM accesses", 32'(n_access), 32'd12);
        check("R8", "acknowledge count", 32'(n_ack), 32'd4);
        finish_run();
    end

endmodule